// File: doc/BRIEF.md
# Packet Buffer Pointer Access Port

This block lets a host processor reach the bytes of a packet held in on-chip packet memory through two registers: a pointer and a data window. The host first loads the pointer with a byte offset inside the packet and three mode bits. The bits select the packet source, turn on post-access stepping and declare whether the coming data accesses are reads or writes. From then on, every access to the data window lands in the chosen packet at the current offset. Accesses may be 8 or 16 bits wide.

The packet number comes from one of two live inputs. One is the packet-number value held by a neighbouring register. The other is the packet at the head of the receive queue. The block adds the offset to the packet number times 256 to form the byte address in the memory, and it owns that memory as a pair of byte-lane block RAMs. In read mode the block keeps the word at the pointer fetched at all times. A read of the data window can therefore follow a pointer load by one cycle, and reads may be issued back to back.

Top module: `pkt_ptr_port`

## Requirements
- R1: After reset the pointer reads back as 0x0000 (offset 0, all mode bits clear) and `host_rdata` is 0.
- R2: A 16-bit write to host address 0 loads the pointer: bit 15 is the receive-select bit, bit 14 the step bit, bit 13 the read-mode bit and bits 10:0 the offset. Bits 12:11 always read back as 0. An 8-bit write to address 0 leaves the pointer unchanged.
- R3: With bit 15 set, the packet number is `rxq_head`. With bit 15 clear, it is `pnr_num`.
- R4: The byte address is packet*256 + offset. A 16-bit access uses the aligned word that holds that byte and ignores offset bit 0, with the even byte in bits 7:0. An 8-bit access uses bits 7:0 of the host data, and an 8-bit read returns zero in bits 15:8.
- R5: With the step bit set, the offset grows by 1 after each accepted 8-bit data access and by 2 after each accepted 16-bit access. With the step bit clear, the offset does not change.
- R6: Stepping stops at offset 2047. The offset never wraps past 2047 to a lower value.
- R7: In read mode, a data read in the cycle after a pointer load returns the addressed data, and consecutive data reads in consecutive cycles return successive data.
- R8: A data write while the read-mode bit is set does not change the memory or the offset. A data read while the read-mode bit is clear returns 0 and does not change the offset.
- R9: Host address 4, two bytes above the data window at address 2, behaves exactly like the data window for reads and writes of both sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host byte address: 0 pointer, 2 data, 4 data alias |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, ignored when `host_wr` is high |
| host_word | input | 1 | 1 for a 16-bit access, 0 for an 8-bit access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data, updated on the edge that takes the read and held until the next read |
| pnr_num | input | 3 | Packet number from the packet-number register |
| rxq_head | input | 3 | Packet number at the head of the receive queue |

## Verification
The assertions check on every cycle that the offset holds when no stepping access is accepted, that it steps by exactly the access size below the limit, that it ends at 2047 near the limit, that the pointer clears on reset, that memory writes always carry a byte enable, and that a read in write mode returns zero. The bench scenarios are needed for the rest: the packet-source choice, the address arithmetic, byte-lane placement, read data after a pointer load and during back-to-back reads, dropped writes in read mode, and the alias window. All of these are compared against a byte-level memory model kept in the bench.

// File: rtl/pap_pkg.sv
package pap_pkg;
  // Mode bits of the pointer register (host-visible positions)
  localparam int BIT_RXSEL  = 15;
  localparam int BIT_STEP   = 14;
  localparam int BIT_RDMODE = 13;

  // Host window map (byte addresses)
  localparam logic [2:0] HA_PTR     = 3'd0;
  localparam logic [2:0] HA_DATA    = 3'd2;
  localparam logic [2:0] HA_DATA_HI = 3'd4;

  typedef struct packed {
    logic rx_sel;
    logic step;
    logic rd_mode;
  } ptr_mode_t;
endpackage

// File: rtl/pap_ptr_reg.sv
module pap_ptr_reg
  import pap_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [15:0]      load_val,
  input  logic             acc,
  input  logic             word_acc,
  output ptr_mode_t        mode_q,
  output ptr_mode_t        mode_d,
  output logic [OFF_W-1:0] off_q,
  output logic [OFF_W-1:0] off_d
);
  localparam logic [OFF_W:0] OFF_MAX = (OFF_W+1)'((1 << OFF_W) - 1);

  logic [OFF_W:0] sum;

  assign sum = {1'b0, off_q} + (word_acc ? (OFF_W+1)'(2) : (OFF_W+1)'(1));

  always_comb begin
    mode_d = mode_q;
    off_d  = off_q;
    if (load) begin
      mode_d.rx_sel  = load_val[BIT_RXSEL];
      mode_d.step    = load_val[BIT_STEP];
      mode_d.rd_mode = load_val[BIT_RDMODE];
      off_d          = load_val[OFF_W-1:0];
    end else if (acc && mode_q.step) begin
      off_d = (sum > OFF_MAX) ? OFF_MAX[OFF_W-1:0] : sum[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      off_q  <= '0;
    end else begin
      mode_q <= mode_d;
      off_q  <= off_d;
    end
  end

  generate
    if (OFF_W < 13) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^load_val[12:OFF_W];
    end
  endgenerate

  // R1: reset clears pointer
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (off_q == '0 && mode_q == '0));

  // R5: offset is frozen unless loaded or stepped
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !(acc && mode_q.step)) |=> $stable(off_q));

  // R5: step equals access size below the limit
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && acc && mode_q.step && ({1'b0, off_q} <= OFF_MAX - 2))
    |=> (int'(off_q) == int'($past(off_q)) + ($past(word_acc) ? 2 : 1)));

  // R6: no wrap at the top of the packet
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && acc && mode_q.step && ({1'b0, off_q} >= OFF_MAX - 1))
    |=> ({1'b0, off_q} == OFF_MAX));
endmodule

// File: rtl/pap_addr_gen.sv
module pap_addr_gen #(
  parameter int PKT_W      = 3,
  parameter int OFF_W      = 11,
  parameter int PAGE_SHIFT = 8,
  parameter int RAM_AW     = 12
) (
  input  logic              rx_sel,
  input  logic [PKT_W-1:0]  pnr_num,
  input  logic [PKT_W-1:0]  rxq_head,
  input  logic [OFF_W-1:0]  off,
  output logic [RAM_AW-1:0] byte_addr
);
  logic [PKT_W-1:0] pkt;

  assign pkt       = rx_sel ? rxq_head : pnr_num;
  assign byte_addr = (RAM_AW'(pkt) << PAGE_SHIFT) + RAM_AW'(off);
endmodule

// File: rtl/pap_ram.sv
module pap_ram #(
  parameter int WAW = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [1:0]     be,
  input  logic [WAW-1:0] waddr,
  input  logic [15:0]    wdata,
  input  logic           re,
  input  logic [WAW-1:0] raddr,
  output logic [15:0]    q
);
  localparam int DEPTH = 1 << WAW;

  generate
    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [7:0] mem [DEPTH];
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (we && be[l]) mem[waddr] <= wdata[l*8 +: 8];
        if (re) lane_q <= mem[raddr];
      end
    end
  endgenerate

  assign q = {g_lane[1].lane_q, g_lane[0].lane_q};

  // R4: every memory write carries at least one byte lane
  p_be_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> (be != 2'b00));
endmodule

// File: rtl/pkt_ptr_port.sv
module pkt_ptr_port
  import pap_pkg::*;
#(
  parameter int PKT_W      = 3,
  parameter int OFF_W      = 11,
  parameter int PAGE_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_word,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  input  logic [PKT_W-1:0] pnr_num,
  input  logic [PKT_W-1:0] rxq_head
);
  localparam int TOP_W  = (PKT_W + PAGE_SHIFT > OFF_W) ? PKT_W + PAGE_SHIFT : OFF_W;
  localparam int RAM_AW = TOP_W + 1;

  ptr_mode_t          mode_q, mode_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic [RAM_AW-1:0]  wr_baddr, rd_baddr;
  logic [15:0]        ram_q, ram_wdata, ptr_view;
  logic [1:0]         ram_be;
  logic               is_ptr, is_data, rd_cyc;
  logic               ptr_load, data_wr, data_rd, lane_q;

  assign is_ptr   = (host_addr == HA_PTR);
  assign is_data  = (host_addr == HA_DATA) || (host_addr == HA_DATA_HI);
  assign rd_cyc   = host_rd && !host_wr;
  assign ptr_load = host_wr && is_ptr && host_word;
  assign data_wr  = host_wr && is_data && !mode_q.rd_mode;
  assign data_rd  = rd_cyc && is_data && mode_q.rd_mode;

  pap_ptr_reg #(.OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(host_wdata),
    .acc(data_wr || data_rd), .word_acc(host_word),
    .mode_q(mode_q), .mode_d(mode_d), .off_q(off_q), .off_d(off_d)
  );

  // Write side uses the pointer as it stands; the fetch side looks at the
  // next pointer so the buffered word always matches the live pointer.
  pap_addr_gen #(.PKT_W(PKT_W), .OFF_W(OFF_W), .PAGE_SHIFT(PAGE_SHIFT),
                 .RAM_AW(RAM_AW)) u_wr_addr (
    .rx_sel(mode_q.rx_sel), .pnr_num(pnr_num), .rxq_head(rxq_head),
    .off(off_q), .byte_addr(wr_baddr)
  );

  pap_addr_gen #(.PKT_W(PKT_W), .OFF_W(OFF_W), .PAGE_SHIFT(PAGE_SHIFT),
                 .RAM_AW(RAM_AW)) u_rd_addr (
    .rx_sel(mode_d.rx_sel), .pnr_num(pnr_num), .rxq_head(rxq_head),
    .off(off_d), .byte_addr(rd_baddr)
  );

  always_comb begin
    if (host_word) begin
      ram_be    = 2'b11;
      ram_wdata = host_wdata;
    end else begin
      ram_be    = wr_baddr[0] ? 2'b10 : 2'b01;
      ram_wdata = {host_wdata[7:0], host_wdata[7:0]};
    end
  end

  pap_ram #(.WAW(RAM_AW - 1)) u_ram (
    .clk(clk), .rst(rst), .we(data_wr), .be(ram_be),
    .waddr(wr_baddr[RAM_AW-1:1]), .wdata(ram_wdata),
    .re(mode_d.rd_mode), .raddr(rd_baddr[RAM_AW-1:1]), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) lane_q <= 1'b0;
    else if (mode_d.rd_mode) lane_q <= rd_baddr[0];
  end

  always_comb begin
    ptr_view              = '0;
    ptr_view[OFF_W-1:0]   = off_q;
    ptr_view[BIT_RXSEL]   = mode_q.rx_sel;
    ptr_view[BIT_STEP]    = mode_q.step;
    ptr_view[BIT_RDMODE]  = mode_q.rd_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (rd_cyc) begin
      if (is_ptr)       host_rdata <= ptr_view;
      else if (data_rd) host_rdata <= host_word ? ram_q
                                    : {8'h00, (lane_q ? ram_q[15:8] : ram_q[7:0])};
      else              host_rdata <= '0;
    end
  end

  // R8: a data read in write mode yields zero
  p_wmode_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_cyc && is_data && !mode_q.rd_mode) |=> (host_rdata == '0));
endmodule

// File: tb/pkt_ptr_port_bench.sv
`timescale 1ns/1ps
module pkt_ptr_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_word = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [2:0]  pnr_num = '0, rxq_head = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_m [4096];
  int   m_off;
  logic m_rx, m_step, m_rd;

  always #2 clk = ~clk;

  pkt_ptr_port u_pkt_ptr_port (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_word(host_word), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .pnr_num(pnr_num), .rxq_head(rxq_head)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int phys();
    return (m_rx ? int'(rxq_head) : int'(pnr_num)) * 256 + m_off;
  endfunction

  function automatic logic [15:0] ptr_exp();
    return {m_rx, m_step, m_rd, 2'b00, 11'(m_off)};
  endfunction

  function automatic logic [15:0] data_exp(input logic word);
    int a;
    a = phys();
    if (word) return {mem_m[a | 1], mem_m[a & ~1]};
    return {8'h00, mem_m[a]};
  endfunction

  function automatic void advance(input logic word);
    if (m_step) begin
      m_off = m_off + (word ? 2 : 1);
      if (m_off > 2047) m_off = 2047;
    end
  endfunction

  task automatic op(input logic [2:0] a, input logic w, input logic r,
                    input logic wd, input logic [15:0] d);
    host_addr = a; host_wr = w; host_rd = r; host_word = wd; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic rx, input logic st, input logic rd, input int off,
                         input logic [2:0] pn, input logic [2:0] rq);
    pnr_num = pn; rxq_head = rq;
    op(3'd0, 1'b1, 1'b0, 1'b1, {rx, st, rd, 2'b00, 11'(off)});
    m_rx = rx; m_step = st; m_rd = rd; m_off = off;
  endtask

  task automatic dwrite(input logic word, input logic [15:0] d, input logic alias_hi);
    int a;
    a = phys();
    op(alias_hi ? 3'd4 : 3'd2, 1'b1, 1'b0, word, d);
    if (!m_rd) begin
      if (word) begin
        mem_m[a & ~1] = d[7:0];
        mem_m[a | 1]  = d[15:8];
      end else begin
        mem_m[a] = d[7:0];
      end
      advance(word);
    end
  endtask

  task automatic dread(input logic word, input logic alias_hi, input string req);
    logic [15:0] exp;
    exp = m_rd ? data_exp(word) : 16'h0000;
    op(alias_hi ? 3'd4 : 3'd2, 1'b0, 1'b1, word, 16'h0);
    check(req, host_rdata, exp);
    if (m_rd) advance(word);
  endtask

  task automatic rd_ptr(input string req);
    op(3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
    check(req, host_rdata, ptr_exp());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem_m[i] = 8'h00;
    m_off = 0; m_rx = 0; m_step = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata after reset", host_rdata, 16'h0000);
    rd_ptr("R1 pointer after reset");

    // Fill all reachable memory in write mode with stepping
    set_ptr(0, 1, 0, 0, 3'd0, 3'd0);
    for (int i = 0; i < 1024; i++) dwrite(1'b1, 16'($urandom), 1'b0);
    set_ptr(0, 1, 0, 256, 3'd7, 3'd0);
    for (int i = 0; i < 896; i++) dwrite(1'b1, 16'($urandom), 1'b0);

    // R2: byte write to pointer ignored, gap bits read as zero
    set_ptr(1, 0, 1, 77, 3'd1, 3'd2);
    op(3'd0, 1'b1, 1'b0, 1'b0, 16'h00FF);
    rd_ptr("R2 byte write to pointer ignored");
    op(3'd0, 1'b1, 1'b0, 1'b1, 16'h3FFF);
    m_rx = 0; m_step = 0; m_rd = 1; m_off = 2047;
    rd_ptr("R2 gap bits read zero");

    // R3: packet source selection
    set_ptr(1, 0, 1, 10, 3'd2, 3'd5);
    dread(1'b1, 1'b0, "R3 receive head source");
    set_ptr(0, 0, 1, 10, 3'd2, 3'd5);
    dread(1'b1, 1'b0, "R3 packet register source");

    // R4: lanes and alignment
    set_ptr(0, 0, 1, 33, 3'd3, 3'd0);
    dread(1'b0, 1'b0, "R4 odd byte read");
    dread(1'b1, 1'b0, "R4 odd offset word aligned");
    set_ptr(0, 0, 0, 41, 3'd3, 3'd0);
    dwrite(1'b0, 16'hA55A, 1'b0);
    set_ptr(0, 0, 1, 40, 3'd3, 3'd0);
    dread(1'b1, 1'b0, "R4 byte write lands in upper lane");

    // R5 and R7: stepping read stream
    set_ptr(0, 1, 1, 100, 3'd4, 3'd0);
    for (int i = 0; i < 4; i++) dread(1'b1, 1'b0, "R7 back-to-back word reads");
    for (int i = 0; i < 3; i++) dread(1'b0, 1'b0, "R7 back-to-back byte reads");
    rd_ptr("R5 offset after stepping");
    set_ptr(0, 0, 1, 200, 3'd4, 3'd0);
    dread(1'b1, 1'b0, "R5 no step read");
    rd_ptr("R5 offset held without step");

    // R6: saturation
    set_ptr(0, 1, 0, 2046, 3'd0, 3'd0);
    dwrite(1'b1, 16'h1234, 1'b0);
    rd_ptr("R6 word step saturates");
    dwrite(1'b0, 16'h0056, 1'b0);
    rd_ptr("R6 byte step at limit");
    set_ptr(0, 1, 1, 2047, 3'd0, 3'd0);
    dread(1'b0, 1'b0, "R6 read at limit");
    rd_ptr("R6 read step at limit");

    // R8: direction gating
    set_ptr(0, 1, 1, 300, 3'd1, 3'd0);
    dwrite(1'b1, 16'hDEAD, 1'b0);
    rd_ptr("R8 write in read mode keeps offset");
    dread(1'b1, 1'b0, "R8 write in read mode keeps memory");
    set_ptr(0, 1, 0, 300, 3'd1, 3'd0);
    dread(1'b1, 1'b0, "R8 read in write mode returns zero");
    rd_ptr("R8 read in write mode keeps offset");

    // R9: alias window
    set_ptr(0, 1, 0, 500, 3'd2, 3'd0);
    dwrite(1'b1, 16'hBEEF, 1'b1);
    dwrite(1'b0, 16'h0077, 1'b1);
    set_ptr(0, 1, 1, 500, 3'd2, 3'd0);
    dread(1'b1, 1'b1, "R9 alias word read");
    dread(1'b0, 1'b1, "R9 alias byte read");
    rd_ptr("R9 alias steps offset");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom % 8);
      case (k)
        0: set_ptr(1'($urandom), 1'($urandom), 1'($urandom),
                   int'($urandom % 2048), 3'($urandom), 3'($urandom));
        1, 2: dwrite(1'($urandom), 16'($urandom), 1'($urandom));
        3, 4, 5: dread(1'($urandom), 1'($urandom), "R4 random data access");
        6: rd_ptr("R5 random pointer readback");
        default: set_ptr(1'($urandom), 1'b1, 1'b1,
                         2040 + int'($urandom % 8), 3'($urandom), 3'($urandom));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule